// File: doc/BRIEF.md
# PWM Input Capture Channel

This block timestamps the edges of one external input against a free-running down-counter. The raw pin is brought into the clock domain through a synchronizer. A control bit can invert it. Its rising and falling transitions are then detected. A rising transition stores the counter value in the rising-capture register and a falling transition stores it in the falling-capture register. Each store sets a sticky indicator for its direction.

Two separate interrupt enables decide which direction raises the shared interrupt flag. Software clears the indicators and the flag by writing 1 to them. A single channel enable gates the counter, both captures and the interrupt output. Software reaches everything through a small register port: writes take one cycle and reads are combinational.

Top module: `pwm_capture_channel`

## Requirements
- R1: The 16-bit counter resets to 0 and holds its value while the channel enable is 0. While the enable is 1 it decreases by one on every clock, and when it is at 0 it loads the period register on the next clock instead.
- R2: The pin passes through two synchronizing flops. A pin change driven between clock edges is acted on at the third rising clock edge that follows it.
- R3: With the invert bit set, a rising pin transition is treated as falling and a falling pin transition as rising. Changing the invert bit does not by itself produce an edge.
- R4: A rising transition stores the counter value present in the cycle before the capturing edge into the rising-capture register and sets the rising indicator (status bit 0).
- R5: A falling transition stores the counter value in the same way into the falling-capture register and sets the falling indicator (status bit 1).
- R6: The interrupt flag (status bit 2) is set by a rising transition only when the rising interrupt enable (control bit 2) is 1, and by a falling transition only when the falling interrupt enable (control bit 3) is 1.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. Without such a write, a status bit stays set.
- R8: When a capture sets a status bit in the same cycle that software writes 1 to clear it, the bit ends up set.
- R9: While the channel enable (control bit 0) is 0, neither capture register changes and no status bit is set.
- R10: The interrupt output equals the interrupt flag ANDed with the channel enable. It falls in the cycle after the enable is written to 0, while the flag itself stays set.
- R11: A later transition of the same direction overwrites that direction's capture register even while its indicator is still set, and the indicator stays set.
- R12: The register addresses are: 0 control (bit 0 enable, bit 1 invert, bit 2 rising interrupt enable, bit 3 falling interrupt enable), 1 period, 2 status, 3 rising capture (read-only), 4 falling capture (read-only) and 5 counter (read-only). Unused addresses read 0, and every register resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Asynchronous input to be timestamped |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| cap_irq | output | 1 | Interrupt request: flag AND channel enable |

## Verification
The hardest case to reach from the ports is the collision of R8, where a write-1-clear reaches a status bit in the very cycle a capture sets it. The bench counts the synchronizer stages itself. It changes the pin half a cycle ahead, waits two rising edges and then holds the clearing write across the third edge, which is the one that performs the capture.

The captured values are also checked cycle by cycle. In the cycle just before the capturing edge, the bench reads the counter through the register port and then requires that exact number in the capture register. A second capture of the same direction, taken without an intervening clear, exercises the overwrite rule.

// File: rtl/pwm_cap_pkg.sv
// Shared register map and field layouts for the capture channel.
// Assumes a 3-bit register address space.
package pwm_cap_pkg;
    localparam int ADDR_W = 3;
    localparam int CTRL_W = 4;
    localparam int STAT_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_PERIOD = 3'd1,
        REG_STATUS = 3'd2,
        REG_RISE   = 3'd3,
        REG_FALL   = 3'd4,
        REG_COUNT  = 3'd5
    } reg_addr_e;

    // Control register, bit 0 is the enable
    typedef struct packed {
        logic fall_ie;
        logic rise_ie;
        logic invert;
        logic enable;
    } ctrl_t;

    // Status register, bit 0 is the rising indicator
    typedef struct packed {
        logic irq;
        logic fell;
        logic rose;
    } status_t;
endpackage

// File: rtl/cap_input_conditioner.sv
// Synchronizes the raw pin and detects its transitions.
// Edges are found on the synchronized raw level and then swapped when the
// invert bit is set, so toggling the invert bit never makes a false edge.
// Assumes STAGES >= 2.
module cap_input_conditioner #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic invert_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              raw_rise;
    logic              raw_fall;

    // Synchronizer chain, one flop per stage
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[s] <= 1'b0;
                    else        sync_q[s] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[s] <= 1'b0;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    // Previous synchronized level, for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Raw edges, then polarity swap when inverted
    always_comb begin
        raw_rise = sync_q[STAGES-1] & ~prev_q;
        raw_fall = ~sync_q[STAGES-1] & prev_q;
        rise_o   = invert_i ? raw_fall : raw_rise;
        fall_o   = invert_i ? raw_rise : raw_fall;
    end
endmodule

// File: rtl/cap_downcounter.sv
// Free-running down-counter that reloads from a period value at zero.
// Assumes the period may change at any time; the new value is used at the
// next reload.
module cap_downcounter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] period_i,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_q;

    // Count down while running, reload at zero, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (run_i) begin
            if (cnt_q == '0)   cnt_q <= period_i;
            else               cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/cap_edge_latch.sv
// One capture direction: a value register and its sticky indicator.
// A capture always overwrites the value. The set wins over a same-cycle clear.
module cap_edge_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture_i,
    input  logic         clear_i,
    input  logic [W-1:0] count_i,
    output logic [W-1:0] value_o,
    output logic         flag_o
);
    logic [W-1:0] val_q;
    logic         flag_q;

    // Store the counter on every qualified capture
    always_ff @(posedge clk) begin
        if (!rst_n)         val_q <= '0;
        else if (capture_i) val_q <= count_i;
    end

    // Sticky indicator, set has priority over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (capture_i) flag_q <= 1'b1;
        else if (clear_i)   flag_q <= 1'b0;
    end

    assign value_o = val_q;
    assign flag_o  = flag_q;
endmodule

// File: rtl/pwm_capture_channel.sv
// One input capture channel: synchronizer, edge detect, down-counter,
// per-direction capture registers, shared interrupt flag and a register port.
// Assumes DATA_W >= CNT_W and at most one register access per cycle.
module pwm_capture_channel
    import pwm_cap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_pin,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cap_irq
);
    localparam int N_DIR = 2;
    localparam int DIR_RISE = 0;
    localparam int DIR_FALL = 1;

    ctrl_t              ctrl_q;
    logic [CNT_W-1:0]   period_q;
    logic               irq_flag_q;
    logic               chan_en;
    logic               rise_evt;
    logic               fall_evt;
    logic [CNT_W-1:0]   count;
    logic               stat_wr;
    status_t            stat_wdata;
    logic               irq_set;
    logic [N_DIR-1:0]   dir_evt;
    logic [N_DIR-1:0]   dir_clr;
    logic [N_DIR-1:0]   dir_flag;
    logic [CNT_W-1:0]   dir_val [N_DIR];

    assign chan_en    = ctrl_q.enable;
    assign stat_wr    = reg_we && (reg_addr == REG_STATUS);
    assign stat_wdata = status_t'(reg_wdata[STAT_W-1:0]);

    // Control and period registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            period_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == REG_CTRL)   ctrl_q   <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (reg_addr == REG_PERIOD) period_q <= reg_wdata[CNT_W-1:0];
        end
    end

    cap_input_conditioner #(.STAGES(SYNC_STAGES)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (cap_pin),
        .invert_i (ctrl_q.invert),
        .rise_o   (rise_evt),
        .fall_o   (fall_evt)
    );

    cap_downcounter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (chan_en),
        .period_i (period_q),
        .count_o  (count)
    );

    // Qualified events and clears per direction
    always_comb begin
        dir_evt[DIR_RISE] = chan_en & rise_evt;
        dir_evt[DIR_FALL] = chan_en & fall_evt;
        dir_clr[DIR_RISE] = stat_wr & stat_wdata.rose;
        dir_clr[DIR_FALL] = stat_wr & stat_wdata.fell;
    end

    generate
        for (genvar d = 0; d < N_DIR; d++) begin : g_dir
            cap_edge_latch #(.W(CNT_W)) u_latch (
                .clk       (clk),
                .rst_n     (rst_n),
                .capture_i (dir_evt[d]),
                .clear_i   (dir_clr[d]),
                .count_i   (count),
                .value_o   (dir_val[d]),
                .flag_o    (dir_flag[d])
            );
        end
    endgenerate

    assign irq_set = (dir_evt[DIR_RISE] & ctrl_q.rise_ie) |
                     (dir_evt[DIR_FALL] & ctrl_q.fall_ie);

    // Shared interrupt flag, set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)                       irq_flag_q <= 1'b0;
        else if (irq_set)                 irq_flag_q <= 1'b1;
        else if (stat_wr & stat_wdata.irq) irq_flag_q <= 1'b0;
    end

    assign cap_irq = irq_flag_q & chan_en;

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL:   reg_rdata = DATA_W'(ctrl_q);
            REG_PERIOD: reg_rdata = DATA_W'(period_q);
            REG_STATUS: reg_rdata = DATA_W'({irq_flag_q, dir_flag[DIR_FALL], dir_flag[DIR_RISE]});
            REG_RISE:   reg_rdata = DATA_W'(dir_val[DIR_RISE]);
            REG_FALL:   reg_rdata = DATA_W'(dir_val[DIR_FALL]);
            REG_COUNT:  reg_rdata = DATA_W'(count);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cap_channel_checker.sv
// Temporal checks on the capture channel, bound into every instance.
module cap_channel_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_stat,
    input logic [2:0]       wr_bits,
    input logic             chan_en,
    input logic             rise_ie,
    input logic             fall_ie,
    input logic             rise_evt,
    input logic             fall_evt,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] rise_val,
    input logic [CNT_W-1:0] fall_val,
    input logic             rise_flag,
    input logic             fall_flag,
    input logic             irq_flag
);
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && count != '0 |=> count == $past(count) - 1'b1);

    assert_count_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && count == '0 |=> count == $past(period));

    assert_rise_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && rise_evt |=> rise_flag && rise_val == $past(count));

    assert_fall_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && fall_evt |=> fall_flag && fall_val == $past(count));

    assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(chan_en && ((rise_evt && rise_ie) || (fall_evt && fall_ie))));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_flag && !(wr_stat && wr_bits[0]) |=> rise_flag);

    assert_frozen_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> $stable(rise_val) && $stable(fall_val));
endmodule

bind pwm_capture_channel cap_channel_checker #(.CNT_W(CNT_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stat   (stat_wr),
    .wr_bits   (reg_wdata[2:0]),
    .chan_en   (chan_en),
    .rise_ie   (ctrl_q.rise_ie),
    .fall_ie   (ctrl_q.fall_ie),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .period    (period_q),
    .count     (count),
    .rise_val  (dir_val[0]),
    .fall_val  (dir_val[1]),
    .rise_flag (dir_flag[0]),
    .fall_flag (dir_flag[1]),
    .irq_flag  (irq_flag_q)
);

// File: tb/pwm_capture_channel_test.sv
// Self-checking bench: a table of edge/configuration vectors, then directed
// tests for reset, counter, capture values, collisions and disable.
module pwm_capture_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        cap_irq;
    int          n_checks = 0;
    int          n_fail = 0;

    localparam logic [2:0] A_CTRL = 3'd0, A_PER = 3'd1, A_STAT = 3'd2,
                           A_RISE = 3'd3, A_FALL = 3'd4, A_CNT = 3'd5;

    // {ctrl[3:0], pin, expected status[2:0], expected irq}
    localparam int NV = 10;
    localparam logic [8:0] VEC [NV] = '{
        9'b0001_1_001_0,  // plain rise, no irq enable
        9'b0101_0_010_0,  // fall, only rise irq enabled
        9'b0101_1_101_1,  // rise with rise irq
        9'b1001_0_110_1,  // fall with fall irq
        9'b0111_1_010_0,  // inverted: pin rise is a fall
        9'b0111_0_101_1,  // inverted: pin fall is a rise
        9'b1011_1_110_1,  // inverted fall with fall irq
        9'b1100_0_000_0,  // channel disabled
        9'b1101_1_101_1,  // both enables, rise
        9'b1101_0_110_1   // both enables, fall
    };

    pwm_capture_channel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_pin   (cap_pin),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cap_irq   (cap_irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d, v, v2, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state of every register
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R12 reset value", 32'(d), 32'd0);
        end
        check("R10 irq after reset", 32'(cap_irq), 32'd0);

        // R1: counter sequence with period 5
        wr(A_PER, 16'd5);
        rd(A_PER, d);
        check("R12 period readback", 32'(d), 32'd5);
        wr(A_CTRL, 16'h1);
        e = 16'd0;
        for (int i = 0; i < 8; i++) begin
            rd(A_CNT, d);
            check("R1 counter step", 32'(d), 32'(e));
            e = (e == 16'd0) ? 16'd5 : e - 16'd1;
            @(negedge clk);
        end
        wr(A_PER, 16'd1000);

        // R3 R4 R5 R6 R9 R10: table walk
        for (int i = 0; i < NV; i++) begin
            wr(A_STAT, 16'h7);
            wr(A_CTRL, {12'd0, VEC[i][8:5]});
            cap_pin = VEC[i][4];
            repeat (4) @(negedge clk);
            rd(A_STAT, d);
            check("R3/R4/R5/R6/R9 table status", 32'(d), 32'(VEC[i][3:1]));
            check("R6/R10 table irq", 32'(cap_irq), 32'(VEC[i][0]));
        end

        // R2 R4: rising capture value and latency
        wr(A_STAT, 16'h7);
        cap_pin = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rd(A_STAT, d);
        check("R2 no capture before third edge", 32'(d[0]), 32'd0);
        rd(A_CNT, v);
        @(negedge clk);
        rd(A_RISE, d);
        check("R4 rising capture value", 32'(d), 32'(v));

        // R5: falling capture value
        repeat (3) @(negedge clk);
        cap_pin = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rd(A_CNT, v2);
        @(negedge clk);
        rd(A_FALL, d);
        check("R5 falling capture value", 32'(d), 32'(v2));

        // R11: second rise without clearing overwrites value
        repeat (3) @(negedge clk);
        cap_pin = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rd(A_CNT, v2);
        @(negedge clk);
        rd(A_RISE, d);
        check("R11 overwrite value", 32'(d), 32'(v2));
        check("R11 new value differs", 32'(d != v), 32'd1);
        rd(A_STAT, d);
        check("R11 indicator stays set", 32'(d[0]), 32'd1);

        // R8: clear write lands on the capturing edge
        wr(A_STAT, 16'h7);
        repeat (2) @(negedge clk);
        cap_pin = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_addr = A_STAT; reg_wdata = 16'h2; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        rd(A_STAT, d);
        check("R8 set wins over clear", 32'(d[2:0]), 32'h6);

        // R7: write 0 has no effect, write 1 clears
        wr(A_STAT, 16'h0);
        rd(A_STAT, d);
        check("R7 write zero keeps bits", 32'(d[2:0]), 32'h6);
        wr(A_STAT, 16'h2);
        rd(A_STAT, d);
        check("R7 write one clears", 32'(d[2:0]), 32'h4);

        // R10 R9 R1: disable drops irq, freezes latches and counter
        wr(A_CTRL, 16'hC);
        check("R10 irq drops on disable", 32'(cap_irq), 32'd0);
        rd(A_STAT, d);
        check("R10 flag kept while disabled", 32'(d[2]), 32'd1);
        rd(A_RISE, v);
        rd(A_CNT, v2);
        cap_pin = 1'b1;
        repeat (5) @(negedge clk);
        rd(A_RISE, d);
        check("R9 latch frozen", 32'(d), 32'(v));
        rd(A_STAT, d);
        check("R9 no indicator", 32'(d[0]), 32'd0);
        rd(A_CNT, d);
        check("R1 counter holds", 32'(d), 32'(v2));
        wr(A_CTRL, 16'hD);
        check("R10 irq returns on enable", 32'(cap_irq), 32'd1);

        // R3: toggling invert alone makes no edge
        wr(A_STAT, 16'h7);
        wr(A_CTRL, 16'hF);
        repeat (4) @(negedge clk);
        rd(A_STAT, d);
        check("R3 invert toggle no edge", 32'(d[2:0]), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule